// File: doc/BRIEF.md
# Min-Sum Check Node Update Unit

This unit performs the check-node half of one iteration in a degree-6 LDPC decoder that uses the min-sum approximation. Each cycle it can accept six incoming bit-to-check messages. For every edge it returns a message whose magnitude is the smallest magnitude seen on the other five edges. The sign of that message is the exclusive-OR of the other five signs.

Incoming messages are in sign-magnitude form: bit 4 is the sign and bits 3:0 are the magnitude, with two integer and two fractional bits. Outgoing messages are in two's complement. In the same pass the unit checks the six hard-decision code bits left over from the previous iteration against the row's parity equation. It reports the result next to the messages, so the decoder does not need a separate pass to test for convergence.

The result is registered: a beat presented with `in_valid` produces its outputs one clock later, marked by `out_valid`. Message lane k sits at bits [5k+4:5k] of each bus.

Top module: `ldpc_cnu`

## Requirements
- R1: Output lane k has magnitude min over j != k of the input magnitude field (bits 3:0 of input lane j).
- R2: When its magnitude is nonzero, output lane k is negative exactly when the XOR of the input sign bits (bit 4) over j != k is 1.
- R3: An output with zero magnitude is encoded as 5'b00000, so negative zero never appears.
- R4: Outputs are two's complement: a positive magnitude m is encoded as m, and a negative one as 32 - m in 5 bits.
- R5: An input with sign bit 1 and magnitude 0 (negative zero) counts as magnitude 0 for every other lane.
- R6: `parity_ok` is 1 exactly when the XOR of the six `code_bits` captured with the beat is 0.
- R7: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 otherwise. Messages and `parity_ok` are updated in that same cycle.
- R8: While `rst_n` is low, `out_valid`, `parity_ok` and every message lane read 0.
- R9: In a cycle with `in_valid` low, the next cycle still shows the previous `msg_out` and `parity_ok`.
- R10: When two or more inputs share the smallest magnitude, every output lane carries that magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| msg_in | input | 30 | Six sign-magnitude messages, lane k at [5k+4:5k] |
| code_bits | input | 6 | Previous-iteration hard decisions of the six connected bits |
| out_valid | output | 1 | Result beat present |
| msg_out | output | 30 | Six two's complement check-to-bit messages |
| parity_ok | output | 1 | Parity equation satisfied by the captured code bits |

## Verification
The checker assumes that `in_valid` and `code_bits` are never unknown after reset. It also assumes that `rst_n` is released away from a clock edge. The stimulus meets both assumptions by driving every input on the falling edge, always from defined values. Any 5-bit pattern is a legal input message, because an input can carry any value in either sign. The bench therefore mixes random beats with directed ones: all-zero, negative zero, tied minima and maximum magnitude. Idle gaps between beats exercise holding.

// File: rtl/ldpc_cnu_pkg.sv
package ldpc_cnu_pkg;
    localparam int CNU_DEG   = 6;
    localparam int CNU_MAG_W = 4;
    localparam int CNU_MSG_W = CNU_MAG_W + 1;
endpackage

// File: rtl/cnu_min_pair.sv
module cnu_min_pair #(
    parameter int DEG   = 6,
    parameter int MAG_W = 4,
    localparam int IDX_W = $clog2(DEG)
) (
    input  logic [DEG*MAG_W-1:0] mags,
    output logic [MAG_W-1:0]     min1,
    output logic [MAG_W-1:0]     min2,
    output logic [IDX_W-1:0]     min1_idx
);
    always_comb begin
        min1     = '1;
        min2     = '1;
        min1_idx = '0;
        for (int i = 0; i < DEG; i++) begin
            if (mags[i*MAG_W +: MAG_W] < min1) begin
                min2     = min1;
                min1     = mags[i*MAG_W +: MAG_W];
                min1_idx = IDX_W'(i);
            end else if (mags[i*MAG_W +: MAG_W] < min2) begin
                min2 = mags[i*MAG_W +: MAG_W];
            end
        end
    end
endmodule

// File: rtl/cnu_sign_parity.sv
module cnu_sign_parity #(
    parameter int DEG = 6
) (
    input  logic [DEG-1:0] signs,
    input  logic [DEG-1:0] code_bits,
    output logic           sign_all,
    output logic           parity_ok
);
    assign sign_all  = ^signs;
    assign parity_ok = ~(^code_bits);
endmodule

// File: rtl/cnu_lane_out.sv
module cnu_lane_out #(
    parameter int DEG   = 6,
    parameter int MAG_W = 4,
    parameter int LANE  = 0,
    localparam int IDX_W = $clog2(DEG),
    localparam int MSG_W = MAG_W + 1
) (
    input  logic [MAG_W-1:0] min1,
    input  logic [MAG_W-1:0] min2,
    input  logic [IDX_W-1:0] min1_idx,
    input  logic             sign_all,
    input  logic             sign_own,
    output logic [MSG_W-1:0] msg_tc
);
    logic [MAG_W-1:0] mag;
    logic             neg;

    always_comb begin
        mag = (min1_idx == IDX_W'(LANE)) ? min2 : min1;
        neg = (sign_all ^ sign_own) && (mag != '0);
        if (neg) msg_tc = MSG_W'(0) - {1'b0, mag};
        else     msg_tc = {1'b0, mag};
    end
endmodule

// File: rtl/ldpc_cnu.sv
module ldpc_cnu
    import ldpc_cnu_pkg::*;
#(
    parameter int DEG   = CNU_DEG,
    parameter int MAG_W = CNU_MAG_W,
    localparam int MSG_W = MAG_W + 1,
    localparam int IDX_W = $clog2(DEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DEG*MSG_W-1:0] msg_in,
    input  logic [DEG-1:0]       code_bits,
    output logic                 out_valid,
    output logic [DEG*MSG_W-1:0] msg_out,
    output logic                 parity_ok
);
    typedef struct packed {
        logic                 vld;
        logic                 par;
        logic [DEG*MSG_W-1:0] msg;
    } cnu_state_t;

    cnu_state_t st_d, st_q;

    logic [DEG*MAG_W-1:0] mags;
    logic [DEG-1:0]       signs;
    logic [MAG_W-1:0]     min1, min2;
    logic [IDX_W-1:0]     min1_idx;
    logic                 sign_all, par_now;
    logic [DEG*MSG_W-1:0] lanes_tc;

    for (genvar g = 0; g < DEG; g++) begin : g_split
        assign mags[g*MAG_W +: MAG_W] = msg_in[g*MSG_W +: MAG_W];
        assign signs[g]               = msg_in[g*MSG_W + MAG_W];
    end

    cnu_min_pair #(.DEG(DEG), .MAG_W(MAG_W)) u_min (
        .mags     (mags),
        .min1     (min1),
        .min2     (min2),
        .min1_idx (min1_idx)
    );

    cnu_sign_parity #(.DEG(DEG)) u_sp (
        .signs     (signs),
        .code_bits (code_bits),
        .sign_all  (sign_all),
        .parity_ok (par_now)
    );

    for (genvar g = 0; g < DEG; g++) begin : g_lane
        cnu_lane_out #(.DEG(DEG), .MAG_W(MAG_W), .LANE(g)) u_lane (
            .min1     (min1),
            .min2     (min2),
            .min1_idx (min1_idx),
            .sign_all (sign_all),
            .sign_own (signs[g]),
            .msg_tc   (lanes_tc[g*MSG_W +: MSG_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.par = par_now;
            st_d.msg = lanes_tc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign parity_ok = st_q.par;
    assign msg_out   = st_q.msg;
endmodule

// File: rtl/ldpc_cnu_chk.sv
module ldpc_cnu_chk #(
    parameter int DEG   = 6,
    parameter int MAG_W = 4,
    localparam int MSG_W = MAG_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [DEG*MSG_W-1:0] msg_in,
    input logic [DEG-1:0]       code_bits,
    input logic                 out_valid,
    input logic [DEG*MSG_W-1:0] msg_out,
    input logic                 parity_ok
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(msg_out) && $stable(parity_ok))); // R9
    AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (parity_ok == ($countones($past(code_bits)) % 2 == 0))); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !parity_ok && msg_out == '0)); // R8

    for (genvar g = 0; g < DEG; g++) begin : g_nz
        AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            msg_out[g*MSG_W +: MSG_W] != {1'b1, {MAG_W{1'b0}}}); // R3
    end
endmodule

bind ldpc_cnu ldpc_cnu_chk #(.DEG(DEG), .MAG_W(MAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .msg_in    (msg_in),
    .code_bits (code_bits),
    .out_valid (out_valid),
    .msg_out   (msg_out),
    .parity_ok (parity_ok)
);

// File: tb/ldpc_cnu_tb.sv
module ldpc_cnu_tb;
    localparam int DEG = 6;
    localparam int MW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [DEG*MW-1:0] msg_in = '0;
    logic [DEG-1:0]  code_bits = '0;
    logic            out_valid;
    logic [DEG*MW-1:0] msg_out;
    logic            parity_ok;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DEG*MW:0] exp_q[$];
    logic [DEG*MW-1:0] last_msg = '0;
    logic            last_par = 1'b0;
    logic            seen = 1'b0;
    logic            done = 1'b0;

    always #4 clk = ~clk;

    ldpc_cnu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .msg_in(msg_in),
        .code_bits(code_bits), .out_valid(out_valid), .msg_out(msg_out),
        .parity_ok(parity_ok)
    );

    function automatic logic [DEG*MW-1:0] model_msgs(logic [DEG*MW-1:0] m);
        logic [DEG*MW-1:0] r;
        for (int k = 0; k < DEG; k++) begin
            logic [3:0] mn;
            logic       sg;
            mn = 4'hF;
            sg = 1'b0;
            for (int j = 0; j < DEG; j++) begin
                if (j != k) begin
                    if (m[j*MW +: 4] < mn) mn = m[j*MW +: 4];
                    sg ^= m[j*MW + 4];
                end
            end
            if (mn == 0)  r[k*MW +: MW] = 5'd0;
            else if (sg)  r[k*MW +: MW] = 5'((32 - int'(mn)) % 32);
            else          r[k*MW +: MW] = {1'b0, mn};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [DEG*MW-1:0] m, input logic [DEG-1:0] cb);
        @(negedge clk);
        in_valid  = 1'b1;
        msg_in    = m;
        code_bits = cb;
        exp_q.push_back({~(^cb), model_msgs(m)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            msg_in   = {DEG*MW{1'b1}};
            code_bits = '1;
        end
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected out_valid", 1, 0);
                end else begin
                    logic [DEG*MW:0] e;
                    e = exp_q.pop_front();
                    for (int k = 0; k < DEG; k++)
                        check(msg_out[k*MW +: MW] == e[k*MW +: MW],
                              $sformatf("R1 R2 R3 R4 R5 R10 lane %0d", k),
                              int'(msg_out[k*MW +: MW]), int'(e[k*MW +: MW]));
                    check(parity_ok == e[DEG*MW], "R6 parity_ok",
                          int'(parity_ok), int'(e[DEG*MW]));
                    last_msg = msg_out;
                    last_par = parity_ok;
                    seen = 1'b1;
                end
            end else if (seen) begin
                check(msg_out == last_msg && parity_ok == last_par,
                      "R9 hold while idle", int'(msg_out[29:0]), int'(last_msg[29:0]));
            end
        end
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0 && parity_ok == 0 && msg_out == '0, "R8 reset state",
              int'({out_valid, parity_ok}), 0);
        rst_n = 1'b1;
        // R1 R2 R4: distinct magnitudes, mixed signs
        drive({5'h13, 5'h07, 5'h19, 5'h02, 5'h0C, 5'h15}, 6'b000000);
        // R10: tied minima
        drive({5'h03, 5'h13, 5'h08, 5'h0F, 5'h03, 5'h1E}, 6'b101000);
        // R3 R5: negative zero and zero
        drive({5'h10, 5'h05, 5'h16, 5'h09, 5'h1A, 5'h0B}, 6'b000001);
        drive({5'h10, 5'h10, 5'h06, 5'h11, 5'h04, 5'h13}, 6'b111111);
        idle(3);
        // R4: maximum magnitudes negative
        drive({6{5'h1F}}, 6'b110100);
        drive({6{5'h0F}}, 6'b010101);
        idle(2);
        for (int i = 0; i < 200; i++) begin
            drive(DEG*MW'($urandom()), DEG'($urandom()));
            if (i % 17 == 0) idle(1);
        end
        idle(4);
        check(exp_q.size() == 0, "R7 all beats returned", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule